// File: doc/BRIEF.md
# Self-Assembling Cellular Memory Array

This block is a small random-access memory that has no central address decoder. It is built from `2**ADDR_W` copies of one storage cell, and every copy runs the same fixed logic. The copies differ only in the signals each one receives while the array grows.

After reset a single seed cell is alive. A pulse on `dev_start` begins a synchronous growth phase of `ADDR_W` steps. On each step every living cell splits once, and its offspring comes alive in a fixed neighbouring slot. The cell that split marks itself as the parent at that level. The offspring copies the lineage the parent had so far and keeps the level unmarked, which records it as the child. At the end of growth, each cell's lineage string is its address: parent at level k means address bit k is 0, and child means bit k is 1.

Once `dev_done` is high, the array behaves as a plain memory. Every cell compares the address bus with its own lineage. The one cell that matches stores `wr_data` when `load` is high and drives its word onto an OR-merged read bus.

Top module: `lineage_ram`

## Requirements
- R1: While reset is applied, `dev_done` is low and `rd_data` is all zeros.
- R2: A `dev_start` pulse seen at a clock edge starts growth. `dev_done` is still low after the following ADDR_W-1 edges, goes high at the ADDR_W-th following edge, and stays high until reset.
- R3: Each growth step doubles the living population, and every cell splits at most once per level. After ADDR_W steps there are 2**ADDR_W living cells. Their lineage is frozen from then on, and each holds a distinct lineage.
- R4: A cell is selected only when, for every address bit k, `addr[k]` XOR its parent-flag k is 1. A parent flag of 1 selects address bit 0, so the cell whose history is child at every level answers the all-ones address. At most one cell is selected at any time, and in the adult phase exactly one is.
- R5: In the adult phase, `load` high writes `wr_data` into the addressed word at the clock edge. The bit update follows the truth table 01000111 over (data, local load, stored bit), indexed 000 to 111 from the left. No other word changes.
- R6: With `load` low, every stored word holds its value, whatever `wr_data` carries.
- R7: `rd_data` is the OR of (select AND stored word) over all cells. It is combinational in `addr`, and an address never written reads as zero.
- R8: Before `dev_done` is high, `load` has no effect on any stored word and `rd_data` stays zero.
- R9: A `dev_start` pulse during growth or in the adult phase is ignored. Timing, lineage and stored data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_start | input | 1 | Pulse that starts the growth phase |
| load | input | 1 | Write strobe for the addressed word (adult phase only) |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the addressed word |
| dev_done | output | 1 | High once growth has finished |

## Verification
The bench builds the array with three address bits and eight data bits, which gives eight cells over three growth levels. With only eight cells, every address can be swept on every pass: reads before any write, writes of distinct computed patterns, hold with `load` low, a single overwrite, and all-ones against all-zeros words. Because all cells fit in one sweep, any flaw in lineage copying, parent marking or select polarity shows up as an aliased or missing word. The growth window is small enough that writes attempted before growth, and restart pulses during it and after it, can be checked edge by edge.

// File: rtl/lram_pkg.sv
`timescale 1ns/1ps
package lram_pkg;

  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_GROW  = 2'd1,
    ST_ADULT = 2'd2
  } dev_state_e;

  // Storage rule: entry i (index {data, local_load, stored}) is bit i.
  // Left-to-right listing 0,1,0,0,0,1,1,1 for indices 000..111.
  localparam logic [7:0] STORE_RULE = 8'b1110_0010;

  // Position of the highest set bit of a positive value.
  function automatic int top_bit(input int v);
    int r;
    r = 0;
    for (int b = 0; b < 31; b++) begin
      if (((v >> b) & 1) == 1) r = b;
    end
    return r;
  endfunction

endpackage

// File: rtl/lram_rst_sync.sv
`timescale 1ns/1ps
module lram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/lram_ctrl.sv
`timescale 1ns/1ps
module lram_ctrl #(
  parameter int STEPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic grow_o,
  output logic adult_o
);
  import lram_pkg::*;

  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  dev_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_SEED: begin
        if (start_i) begin
          state_d = ST_GROW;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_GROW: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_ADULT;
      end
      ST_ADULT: begin
        state_d = ST_ADULT;
      end
      default: state_d = ST_SEED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign grow_o  = (state_q == ST_GROW);
  assign adult_o = (state_q == ST_ADULT);

  // R2
  grow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grow_o |-> (cnt_q < CW'(STEPS)));

  // R2
  adult_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adult_o |=> adult_o);

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grow_o && start_i && (cnt_q != LAST)) |=> (grow_o && (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/lram_cell.sv
`timescale 1ns/1ps
module lram_cell #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_i,
  input  logic              grow_i,
  input  logic              adult_i,
  input  logic              born_i,
  input  logic [ADDR_W-1:0] in_div_i,
  input  logic [ADDR_W-1:0] in_par_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              alive_o,
  output logic [ADDR_W-1:0] split_o,
  output logic [ADDR_W-1:0] div_o,
  output logic [ADDR_W-1:0] par_o,
  output logic              match_o,
  output logic [DATA_W-1:0] rdata_o
);
  import lram_pkg::*;

  logic              alive_q, alive_d;
  logic [ADDR_W-1:0] div_q, div_d;
  logic [ADDR_W-1:0] par_q, par_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              lineage_en;
  logic              alive;
  logic [ADDR_W-1:0] next_lvl;
  logic              store_en;

  assign alive    = alive_q | seed_i;
  assign next_lvl = (~div_q) & (div_q + 1'b1);

  // Division request is the inverse of the divided flag at the next level.
  always_comb begin
    split_o = '0;
    if (alive && grow_i) split_o = next_lvl;
  end

  // Sticky flags; all merges are OR.
  always_comb begin
    alive_d = alive_q | seed_i | born_i;
    div_d   = div_q | split_o | (born_i ? in_div_i : '0);
    par_d   = par_q | split_o | (born_i ? in_par_i : '0);
  end

  assign lineage_en = ~adult_i;

  assign match_o  = adult_i & alive & (&(addr_i ^ par_q));
  assign store_en = match_o & load_i;

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      data_d[b] = STORE_RULE[{wdata_i[b], store_en, data_q[b]}];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      div_q   <= '0;
      par_q   <= '0;
    end else if (lineage_en) begin
      alive_q <= alive_d;
      div_q   <= div_d;
      par_q   <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign alive_o = alive;
  assign div_o   = div_q | next_lvl;
  assign par_o   = par_q;
  assign rdata_o = match_o ? data_q : '0;

  // R3
  one_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(split_o));

  // R3
  lineage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adult_i |=> $stable(par_q));

  // R5
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && load_i) |=> (data_q == $past(wdata_i)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_o && load_i) |=> $stable(data_q));

endmodule

// File: rtl/lram_or_net.sv
`timescale 1ns/1ps
module lram_or_net #(
  parameter int CELLS  = 8,
  parameter int DATA_W = 8
) (
  input  logic [CELLS*DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]       merged_o
);
  always_comb begin
    merged_o = '0;
    for (int c = 0; c < CELLS; c++) begin
      merged_o = merged_o | words_i[c*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/lineage_ram.sv
`timescale 1ns/1ps
module lineage_ram #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_start,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              dev_done
);
  localparam int CELLS = 1 << ADDR_W;

  logic rst_sync_n;
  logic grow;
  logic adult;

  logic [CELLS-1:0]        alive_w;
  logic [CELLS-1:0]        match_w;
  logic [CELLS-1:0]        born_w;
  logic [CELLS*ADDR_W-1:0] split_w;
  logic [CELLS*ADDR_W-1:0] div_w;
  logic [CELLS*ADDR_W-1:0] par_w;
  logic [CELLS*ADDR_W-1:0] in_div_w;
  logic [CELLS*ADDR_W-1:0] in_par_w;
  logic [CELLS*DATA_W-1:0] rdata_w;

  lram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lram_ctrl #(.STEPS(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (dev_start),
    .grow_o  (grow),
    .adult_o (adult)
  );

  // Static neighbour wiring: slot j is the offspring of slot j minus its
  // top set bit, born at the level of that bit.
  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    if (j == 0) begin : g_seed
      assign born_w[j]                        = 1'b0;
      assign in_div_w[j*ADDR_W +: ADDR_W]     = '0;
      assign in_par_w[j*ADDR_W +: ADDR_W]     = '0;
    end else begin : g_child
      localparam int LVL = lram_pkg::top_bit(j);
      localparam int PAR = j - (1 << LVL);
      assign born_w[j]                        = split_w[PAR*ADDR_W + LVL];
      assign in_div_w[j*ADDR_W +: ADDR_W]     = div_w[PAR*ADDR_W +: ADDR_W];
      assign in_par_w[j*ADDR_W +: ADDR_W]     = par_w[PAR*ADDR_W +: ADDR_W];
    end

    lram_cell #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .seed_i   (j == 0),
      .grow_i   (grow),
      .adult_i  (adult),
      .born_i   (born_w[j]),
      .in_div_i (in_div_w[j*ADDR_W +: ADDR_W]),
      .in_par_i (in_par_w[j*ADDR_W +: ADDR_W]),
      .addr_i   (addr),
      .load_i   (load),
      .wdata_i  (wr_data),
      .alive_o  (alive_w[j]),
      .split_o  (split_w[j*ADDR_W +: ADDR_W]),
      .div_o    (div_w[j*ADDR_W +: ADDR_W]),
      .par_o    (par_w[j*ADDR_W +: ADDR_W]),
      .match_o  (match_w[j]),
      .rdata_o  (rdata_w[j*DATA_W +: DATA_W])
    );

    // R3
    lineage_is_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      adult |-> (par_w[j*ADDR_W +: ADDR_W] == ~ADDR_W'(j)));
  end

  lram_or_net #(.CELLS(CELLS), .DATA_W(DATA_W)) u_or (
    .words_i  (rdata_w),
    .merged_o (rd_data)
  );

  assign dev_done = adult;

  // R3
  doubling_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grow |=> ($countones(alive_w) == 2 * $past($countones(alive_w))));

  // R3
  full_population_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adult |-> ((&alive_w) && (&div_w)));

  // R3
  quiet_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !grow |-> (split_w == '0));

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adult |-> ($countones(match_w) == 1));

  // R8
  silent_growth_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !adult |-> ((rd_data == '0) && (match_w == '0)));

endmodule

// File: tb/lineage_ram_tb.sv
`timescale 1ns/1ps
module lineage_ram_tb;
  localparam int K = 3;
  localparam int L = 8;
  localparam int N = 1 << K;

  logic         clk;
  logic         rst_n;
  logic         dev_start;
  logic         load;
  logic [K-1:0] addr;
  logic [L-1:0] wr_data;
  logic [L-1:0] rd_data;
  logic         dev_done;

  int checks;
  int errors;
  bit finished;
  logic [L-1:0] ref_mem [N];

  lineage_ram #(.ADDR_W(K), .DATA_W(L)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_start (dev_start),
    .load      (load),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .dev_done  (dev_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pat_a(input int a);
    return L'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic write_word(input int a, input logic [L-1:0] d);
    @(negedge clk);
    addr    = K'(a);
    wr_data = d;
    load    = 1'b1;
    @(negedge clk);
    load    = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      addr = K'(a);
      #1;
      chk(req, 32'(rd_data), 32'(ref_mem[a]));
    end
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; dev_start = 1'b0; load = 1'b0; addr = '0; wr_data = '0;
    for (int a = 0; a < N; a++) ref_mem[a] = '0;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 done in reset", 32'(dev_done), 32'd0);
    chk("R1 read in reset", 32'(rd_data), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: write attempt before growth is ignored
    write_word(5, 8'hAA);
    #1;
    chk("R8 read before growth", 32'(rd_data), 32'd0);

    // R2: growth timing
    @(negedge clk);
    dev_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dev_start = 1'b0;
    #1;
    chk("R8 read while growing", 32'(rd_data), 32'd0);
    chk("R2 done early", 32'(dev_done), 32'd0);
    // R9: restart pulse during growth
    dev_start = 1'b1;
    repeat (K - 1) @(posedge clk);
    @(negedge clk);
    dev_start = 1'b0;
    #1;
    chk("R2 done one edge before", 32'(dev_done), 32'd0);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R2 done at last step", 32'(dev_done), 32'd1);

    // R7 / R8: nothing stored yet, including the pre-growth write
    read_all("R7 unwritten reads zero");

    // R5 / R3 / R4: distinct words everywhere
    for (int a = 0; a < N; a++) begin
      write_word(a, pat_a(a));
      ref_mem[a] = pat_a(a);
    end
    read_all("R5 R3 R4 readback");

    // R6: data present with load low
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      addr = K'(a);
      wr_data = ~pat_a(a);
      load = 1'b0;
    end
    read_all("R6 hold with load low");

    // R5: single overwrite leaves others intact
    write_word(3, 8'h5A);
    ref_mem[3] = 8'h5A;
    read_all("R5 overwrite one word");

    // R9: restart in adult phase
    @(negedge clk);
    dev_start = 1'b1;
    @(negedge clk);
    dev_start = 1'b0;
    repeat (K + 2) @(negedge clk);
    #1;
    chk("R9 done after restart", 32'(dev_done), 32'd1);
    read_all("R9 data after restart");

    // R5: all ones vs all zeros
    for (int a = 0; a < N; a++) begin
      write_word(a, (a % 2 == 0) ? 8'hFF : 8'h00);
      ref_mem[a] = (a % 2 == 0) ? 8'hFF : 8'h00;
    end
    read_all("R5 ones and zeros");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule